// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block sits between a CPU core and external code and data memories of up to 64 KB each. It carries every access over a narrow multiplexed bus. A shared 8-bit port first carries the low byte of the address and then the data byte. A second 8-bit port holds the high address byte for the whole access. An active-high latch-enable pulse marks the window in which an external transparent latch captures the low address. The shared port is then released for a read, or switched to the write data.

Each external access takes one machine cycle of 12 clocks, numbered phase 0 to 11. Instruction fetches use an active-low code strobe. Data reads and data writes each have their own active-low strobe. An external-access select input controls code fetches. When it is low, every fetch goes to the bus. When it is high, a fetch below the internal code size is served internally and no bus cycle is run. The core presents one request at a time with a valid/ready handshake. A new request can be accepted in the last phase of a running access, so that machine cycles run back to back.

Top module: `mbi_top`

## Requirements
- R1: While reset is asserted, and until the two-stage reset release completes, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `ad_oe` is 0, `rsp_valid` and `int_sel` are 0, and `req_ready` is 0.
- R2: An external access starts in the clock after acceptance. Its phases count 0 to 11. `ale` is 1 in phases 0–2 only. `ad_out` carries address bits 7:0 with `ad_oe`=1 in phases 0–3. `hi_addr` shows address bits 15:8 from the clock after acceptance until the next external access is accepted.
- R3: For a fetch or a data read, `ad_oe` is 0 in phases 4–11, so the port is released only after `ale` has fallen.
- R4: The strobe is low in phases 5–10 and high at every other time. `psen_n` is the strobe for fetches, `rd_n` for data reads and `wr_n` for data writes.
- R5: For a fetch or a read, `ad_in` is captured at the clock edge that ends phase 10, when the strobe rises. `rsp_valid` is 1 for exactly phase 11, with the captured byte on `rsp_data`.
- R6: For a data write, `ad_oe` stays 1 in phases 4–11 and `ad_out` carries `req_wdata`. The data is therefore held for one clock after `wr_n` rises.
- R7: A fetch accepted while `ext_access_n`=1 with an address below 8192 runs no bus cycle, and `int_sel` pulses for the one clock after acceptance. With `ext_access_n`=0, or with an address of 8192 or more, the fetch runs on the bus.
- R8: At most one of `psen_n`, `rd_n` and `wr_n` is low at any time, and none of them is low while `ale` is 1.
- R9: `req_ready` is 1 when no access is running, or in phase 11 of a running access. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1, so an access accepted in phase 11 starts at phase 0 in the next clock.
- R10: Request encoding: `req_code`=1 means fetch, whatever the value of `req_we`. `req_code`=0 with `req_we`=1 means data write, and `req_code`=0 with `req_we`=0 means data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through two flops |
| req_valid | input | 1 | Core presents a request |
| req_code | input | 1 | 1 = instruction fetch |
| req_we | input | 1 | 1 = data write (only when req_code is 0) |
| req_addr | input | 16 | Byte address in the selected space |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request can be accepted this clock |
| rsp_valid | output | 1 | Read or fetch data valid |
| rsp_data | output | 8 | Captured read or fetch byte |
| int_sel | output | 1 | Fetch served from internal code memory |
| ext_access_n | input | 1 | 0 = all code fetches external |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| hi_addr | output | 8 | High address byte port |
| ad_out | output | 8 | Shared port, output value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port, input value |

## Verification
The hardest condition to reach is a request that is accepted in phase 11 of a running access. In that clock one access ends and the next one loads new address and type. A second such condition is an internal fetch that is accepted in that same phase, which must end the bus activity without starting a new cycle. The stimulus holds `req_valid` high across accesses with random gaps of zero to three clocks, and it toggles `ext_access_n` during the run. It also uses fetch addresses on both sides of the 8192 boundary, so that these overlaps occur many times. Reads are checked through a transparent-latch model in the bench, which answers from the address it captured while `ale` was high.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_DRD   = 2'd1,
    ACC_DWR   = 2'd2
  } acc_kind_t;
endpackage

// File: rtl/mbi_rst_sync.sv
module mbi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/mbi_route.sv
module mbi_route
  import mbi_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int INT_CODE_BYTES = 8192
) (
  input  logic              req_code,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              ext_access_n,
  output acc_kind_t         kind,
  output logic              internal
);
  localparam int CW = 33;
  localparam logic [CW-1:0] LIMIT = CW'(INT_CODE_BYTES);

  logic [CW-1:0] addr_wide;

  always_comb begin
    addr_wide = CW'(req_addr);
    if (req_code) begin
      kind = ACC_FETCH;
    end else if (req_we) begin
      kind = ACC_DWR;
    end else begin
      kind = ACC_DRD;
    end
    internal = req_code && ext_access_n && (addr_wide < LIMIT);
  end
endmodule

// File: rtl/mbi_seq.sv
module mbi_seq
  import mbi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CYC    = 12,
  localparam int PW    = $clog2(CYC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  acc_kind_t         kind_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic              active,
  output logic [PW-1:0]     phase,
  output acc_kind_t         kind,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              last
);
  localparam logic [PW-1:0] LAST_PH = PW'(CYC - 1);

  logic              active_d;
  logic [PW-1:0]     phase_d;
  logic              load_en;
  logic              adv_en;

  always_comb begin
    last     = active && (phase == LAST_PH);
    load_en  = start;
    adv_en   = active && !start;
    active_d = active;
    phase_d  = phase;
    if (load_en) begin
      active_d = 1'b1;
      phase_d  = '0;
    end else if (adv_en) begin
      if (last) begin
        active_d = 1'b0;
        phase_d  = '0;
      end else begin
        phase_d  = phase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= '0;
    end else begin
      active <= active_d;
      phase  <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind  <= ACC_FETCH;
      addr  <= '0;
      wdata <= '0;
    end else if (load_en) begin
      kind  <= kind_in;
      addr  <= addr_in;
      wdata <= wdata_in;
    end
  end

  assert_start_phase0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && phase == '0));

  assert_end_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !active);
endmodule

// File: rtl/mbi_pins.sv
module mbi_pins
  import mbi_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int CYC       = 12,
  parameter int ALE_W     = 3,
  parameter int ADDR_HOLD = 4,
  parameter int STB_ON    = 5,
  parameter int STB_OFF   = 11,
  localparam int PW       = $clog2(CYC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     active,
  input  logic [PW-1:0]            phase,
  input  acc_kind_t                kind,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [ADDR_W-DATA_W-1:0] hi_addr,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe
);
  localparam logic [PW-1:0] PH_ALE  = PW'(ALE_W);
  localparam logic [PW-1:0] PH_HOLD = PW'(ADDR_HOLD);
  localparam logic [PW-1:0] PH_ON   = PW'(STB_ON);
  localparam logic [PW-1:0] PH_OFF  = PW'(STB_OFF);

  logic addr_ph;
  logic strobe;

  always_comb begin
    addr_ph = active && (phase < PH_HOLD);
    ale     = active && (phase < PH_ALE);
    strobe  = active && (phase >= PH_ON) && (phase < PH_OFF);
    psen_n  = !(strobe && kind == ACC_FETCH);
    rd_n    = !(strobe && kind == ACC_DRD);
    wr_n    = !(strobe && kind == ACC_DWR);
    ad_oe   = addr_ph || (active && kind == ACC_DWR);
    if (addr_ph) begin
      ad_out = addr[DATA_W-1:0];
    end else if (ad_oe) begin
      ad_out = wdata;
    end else begin
      ad_out = '0;
    end
    hi_addr = addr[ADDR_W-1:DATA_W];
  end

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

  assert_no_strobe_in_ale_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n));

  assert_ale_while_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ad_oe);

  assert_write_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  assert_strobe_after_ale_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(psen_n) || $fell(rd_n) || $fell(wr_n)) |-> $past(!ale));
endmodule

// File: rtl/mbi_top.sv
module mbi_top
  import mbi_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 8,
  parameter int CYC            = 12,
  parameter int ALE_W          = 3,
  parameter int ADDR_HOLD      = 4,
  parameter int STB_ON         = 5,
  parameter int STB_OFF        = 11,
  parameter int INT_CODE_BYTES = 8192
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_code,
  input  logic                     req_we,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_ready,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     int_sel,
  input  logic                     ext_access_n,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [ADDR_W-DATA_W-1:0] hi_addr,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in
);
  localparam int PW = $clog2(CYC);
  localparam logic [PW-1:0] PH_CAP = PW'(STB_OFF - 1);

  logic              rst_sync_n;
  acc_kind_t         req_kind;
  logic              req_internal;
  logic              accept;
  logic              start_ext;
  logic              active;
  logic [PW-1:0]     phase;
  acc_kind_t         kind;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic              last;
  logic              cap_en;
  logic              rsp_valid_d;
  logic              int_sel_d;

  mbi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mbi_route #(
    .ADDR_W         (ADDR_W),
    .INT_CODE_BYTES (INT_CODE_BYTES)
  ) u_route (
    .req_code     (req_code),
    .req_we       (req_we),
    .req_addr     (req_addr),
    .ext_access_n (ext_access_n),
    .kind         (req_kind),
    .internal     (req_internal)
  );

  always_comb begin
    req_ready   = rst_sync_n && (!active || last);
    accept      = req_valid && req_ready;
    start_ext   = accept && !req_internal;
    int_sel_d   = accept && req_internal;
    cap_en      = active && (phase == PH_CAP) && (kind != ACC_DWR);
    rsp_valid_d = cap_en;
  end

  mbi_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CYC    (CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start_ext),
    .kind_in  (req_kind),
    .addr_in  (req_addr),
    .wdata_in (req_wdata),
    .active   (active),
    .phase    (phase),
    .kind     (kind),
    .addr     (addr),
    .wdata    (wdata),
    .last     (last)
  );

  mbi_pins #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CYC       (CYC),
    .ALE_W     (ALE_W),
    .ADDR_HOLD (ADDR_HOLD),
    .STB_ON    (STB_ON),
    .STB_OFF   (STB_OFF)
  ) u_pins (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .active  (active),
    .phase   (phase),
    .kind    (kind),
    .addr    (addr),
    .wdata   (wdata),
    .ale     (ale),
    .psen_n  (psen_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .hi_addr (hi_addr),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      int_sel   <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
      int_sel   <= int_sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_data <= '0;
    end else if (cap_en) begin
      rsp_data <= ad_in;
    end
  end

  assert_rsp_on_strobe_rise_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> ($past(!rd_n || !psen_n) && rd_n && psen_n));

  assert_int_needs_select_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    int_sel |-> $past(ext_access_n));

  assert_int_no_bus_start_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (int_sel && !$past(active)) |-> !ale);
endmodule

// File: tb/sim_mbi_top.sv
`timescale 1ns/1ps
module sim_mbi_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_code;
  logic        req_we;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        int_sel;
  logic        ext_access_n;
  logic        ale;
  logic        psen_n;
  logic        rd_n;
  logic        wr_n;
  logic [7:0]  hi_addr;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in;

  mbi_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .int_sel(int_sel), .ext_access_n(ext_access_n), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .hi_addr(hi_addr),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a, input bit code);
    if (code) return a[7:0] ^ a[15:8] ^ 8'h5A;
    return a[7:0] + a[15:8] + 8'h33;
  endfunction

  // external transparent address latch and memory model
  logic [7:0] lat = 8'h00;
  always @(ale or ad_out) if (ale) lat = ad_out;
  always_comb begin
    if (!psen_n)     ad_in = pat({hi_addr, lat}, 1'b1);
    else if (!rd_n)  ad_in = pat({hi_addr, lat}, 1'b0);
    else             ad_in = 8'hEE;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // reference model, kinds: 0 fetch, 1 read, 2 write
  bit         m_act = 0;
  int         m_ph = 0;
  int         m_kind = 0;
  logic [15:0] m_addr = 16'h0;
  logic [7:0]  m_wd = 8'h0;
  bit         m_rv = 0;
  logic [7:0]  m_rdata = 8'h0;
  bit         m_int = 0;
  int         m_cnt = 0;

  always @(posedge clk) begin
    bit rdy, acc, inn;
    cyc++;
    if (!rst_n) begin
      m_act = 0; m_ph = 0; m_kind = 0; m_addr = 16'h0; m_wd = 8'h0;
      m_rv = 0; m_rdata = 8'h0; m_int = 0; m_cnt = 0;
    end else if (m_cnt >= 2) begin
      rdy = !m_act || m_ph == 11;
      acc = req_valid && rdy;
      inn = req_code && ext_access_n && (req_addr < 16'h2000);
      m_rv = m_act && m_ph == 10 && m_kind != 2;
      if (m_rv) m_rdata = pat(m_addr, m_kind == 0);
      m_int = acc && inn;
      if (acc && !inn) begin
        m_act = 1; m_ph = 0;
        m_kind = req_code ? 0 : (req_we ? 2 : 1);
        m_addr = req_addr; m_wd = req_wdata;
      end else if (m_act) begin
        if (m_ph == 11) m_act = 0;
        else m_ph++;
      end
    end else begin
      m_cnt++;
    end
  end

  int saw_wr = 0;
  int saw_psen = 0;

  always @(negedge clk) begin
    bit e_ale, e_oe, stb;
    if (!done) begin
      e_ale = m_act && m_ph < 3;
      e_oe  = m_act && (m_ph < 4 || m_kind == 2);
      stb   = m_act && m_ph >= 5 && m_ph <= 10;
      chk("R2 ale", 16'(ale), 16'(e_ale));
      chk("R2 hi_addr", 16'(hi_addr), 16'(m_addr[15:8]));
      chk("R3 ad_oe", 16'(ad_oe), 16'(e_oe));
      if (e_oe) chk("R6 ad_out", 16'(ad_out), 16'((m_ph < 4) ? m_addr[7:0] : m_wd));
      chk("R4 psen_n", 16'(psen_n), 16'(!(stb && m_kind == 0)));
      chk("R4 rd_n", 16'(rd_n), 16'(!(stb && m_kind == 1)));
      chk("R4 wr_n", 16'(wr_n), 16'(!(stb && m_kind == 2)));
      chk("R5 rsp_valid", 16'(rsp_valid), 16'(m_rv));
      if (m_rv) chk("R5 rsp_data", 16'(rsp_data), 16'(m_rdata));
      chk("R7 int_sel", 16'(int_sel), 16'(m_int));
      chk("R9 req_ready", 16'(req_ready), 16'(m_cnt >= 2 && (!m_act || m_ph == 11)));
      chk("R8 single strobe", 16'(($countones({~psen_n, ~rd_n, ~wr_n}) > 1) || (ale && !(psen_n && rd_n && wr_n))), 16'd0);
      if (!wr_n) begin
        saw_wr++;
        chk("R2 write latch", {hi_addr, lat}, m_addr);
      end
      if (!psen_n) saw_psen++;
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
      $finish;
    end
  end

  task automatic issue(input bit code, input bit we, input logic [15:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_code = code; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic gap(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] nxt(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_code = 1'b0; req_we = 1'b0;
    req_addr = 16'h0; req_wdata = 8'h0; ext_access_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ale", 16'(ale), 16'd0);
    chk("R1 psen_n", 16'(psen_n), 16'd1);
    chk("R1 rd_n", 16'(rd_n), 16'd1);
    chk("R1 wr_n", 16'(wr_n), 16'd1);
    chk("R1 ad_oe", 16'(ad_oe), 16'd0);
    chk("R1 rsp_valid", 16'(rsp_valid), 16'd0);
    chk("R1 int_sel", 16'(int_sel), 16'd0);
    chk("R1 req_ready", 16'(req_ready), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready held in release", 16'(req_ready), 16'd0);
    repeat (3) @(negedge clk);

    // R7 external select low: low addresses go to the bus
    issue(1'b1, 1'b0, 16'h0010, 8'h00); gap(14);
    issue(1'b1, 1'b0, 16'h1FFF, 8'h00); gap(14);
    // R7 external select high: internal below 8192
    ext_access_n = 1'b1;
    issue(1'b1, 1'b0, 16'h0010, 8'h00); gap(3);
    issue(1'b1, 1'b0, 16'h1FFF, 8'h00); gap(3);
    issue(1'b1, 1'b0, 16'h2000, 8'h00); gap(14);
    // data reads and writes, R6, back to back R9
    issue(1'b0, 1'b0, 16'h1234, 8'h00); gap(14);
    issue(1'b0, 1'b1, 16'hABCD, 8'h5C); gap(14);
    issue(1'b0, 1'b0, 16'hFFFF, 8'h00);
    issue(1'b0, 1'b1, 16'h0000, 8'hA5);
    issue(1'b1, 1'b0, 16'h3456, 8'h00);
    issue(1'b1, 1'b0, 16'h0100, 8'h00);
    gap(14);
    // R10 fetch wins over write enable
    saw_wr = 0; saw_psen = 0;
    issue(1'b1, 1'b1, 16'h4321, 8'h77); gap(14);
    chk("R10 no write strobe", 16'(saw_wr), 16'd0);
    chk("R10 fetch strobe cycles", 16'(saw_psen), 16'd6);

    for (int i = 0; i < 300; i++) begin
      lfsr = nxt(lfsr);
      if (i % 50 == 0) ext_access_n = lfsr[3];
      issue(lfsr[0], lfsr[1], {lfsr[15:8] & 8'h3F, lfsr[7:0]} ^ {lfsr[2], 15'h0}, lfsr[11:4]);
      lfsr = nxt(lfsr);
      if (lfsr[1:0] != 2'b00) gap(int'(lfsr[1:0]));
    end
    gap(16);
    done = 1;
    summary();
    $finish;
  end
endmodule